// File: doc/BRIEF.md
# Bus Target Address Decode and Claim

This block is the responding side of a 32-bit multiplexed address/data bus with active-low framing. While the device is not the bus master, the block watches every clock for the start of a transaction. It treats the first clock in which the frame strobe goes low after an idle bus as the address phase. There it decodes the command on the command/byte-enable lines. It compares the address with two programmable base registers, one for memory space and one for I/O space. Configuration commands are not matched by address: they are accepted when a dedicated chip-select input is high.

The block claims a matching transaction with medium decode timing. It then completes exactly one doubleword. On a read it drives register data. On a write it updates only the enabled byte lanes of a small register file or of the base registers. After the data transfer it drives the claim strobes high for one clock and then releases them.

Top module: `pci_target_claim`

## Requirements
- R1: After reset, `devsel_n` and `trdy_n` are 1 and `ctl_oe` and `ad_oe` are 0. Both base registers are 0, so memory and I/O space are disabled and a memory read at address 0 is not claimed.
- R2: An address is decoded only at a rising edge where `frame_n` is 0 and, at the previous edge, both `frame_n` and `irdy_n` were 1. Address and command values seen later in the same transaction are never decoded.
- R3: Commands 4'b1010 (configuration read) and 4'b1011 (configuration write) are claimed only when `idsel` is 1 and AD[1:0] is 2'b00. AD[7:2] selects a configuration doubleword. Index 0 is the memory base and index 1 is the I/O base. In each base, bits [31:WB] hold the address, bit 0 is the enable, and all other bits read 0, where WB = clog2(NREG)+2. Every other index reads 0 and ignores writes.
- R4: Commands 4'b0110 (memory read) and 4'b0111 (memory write) are claimed when the memory enable is 1 and AD[31:WB] equals the memory base bits [31:WB]. AD[WB-1:2] selects the register.
- R5: Commands 4'b0010 (I/O read) and 4'b0011 (I/O write) are claimed in the same way against the I/O base and reach the same register file.
- R6: No other command is claimed. No transaction is claimed when `bus_master` is 1 at the address phase.
- R7: For a claimed address sampled at edge N, `devsel_n` and `trdy_n` are both 0 with `ctl_oe` 1 from edge N+1 until the data transfer. After edge N they are still 1.
- R8: The data transfer happens at the first edge where `irdy_n` is 0 while the claim is held. Any number of clocks with `irdy_n` high keeps the claim. On a claimed read (command bit 0 is 0), `ad_oe` is 1 and `ad_out` carries the selected doubleword. On a write, `ad_oe` stays 0.
- R9: On a write transfer, byte lane b (AD[8b+7:8b]) is updated only if `cbe_n[b]` is 0. `cbe_n[0]` controls AD[7:0] and `cbe_n[3]` controls AD[31:24]. Disabled lanes keep their value.
- R10: After the transfer edge, `devsel_n` and `trdy_n` are 1 with `ctl_oe` still 1 and `ad_oe` 0 for one clock. After the next edge, `ctl_oe` is 0.
- R11: During a transaction the block does not claim, `devsel_n` stays 1 and `ctl_oe` and `ad_oe` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_master | input | 1 | High while this device is the bus master |
| frame_n | input | 1 | Transaction frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration chip select |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| ad_in | input | 32 | Address/data bus as sampled |
| ad_out | output | 32 | Read data toward the bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| ctl_oe | output | 1 | Drive enable for `devsel_n` and `trdy_n` |

## Verification
The bench goes after the ways a decoder can claim the wrong cycle. A configuration command with `idsel` low or with AD[1:0] not 00 must not be claimed; a design that ignored either condition would answer cycles meant for another device. Undefined commands carrying a matching address, and cycles started while `bus_master` is high, must also be ignored. A frame held low with a matching address on its second clock must not be taken; a design that decodes on every low-frame clock would claim in mid-transfer.

Partial byte enables and the masked bits of the base registers catch designs that write whole words. Write-only enable bits would also show up through the readback. Initiator wait states catch a claim that is dropped too early. The release sequence is checked edge by edge, so a design without the one-clock high turnaround, or one that drives AD after the transfer, is reported.

// File: rtl/pci_target_claim.sv
module pci_target_claim #(
  parameter int NREG = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_master,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        ctl_oe
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int WB = IW + 2;
  localparam logic [31:0] BMASK = ({32{1'b1}} << WB) | 32'h1;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_XFER, S_TAR} st_t;

  st_t          st;
  logic         idle_q, rd_q, cfg_q;
  logic [5:0]   cidx_q;
  logic [IW-1:0] ridx_q;
  logic [31:0]  mem_base, io_base;
  logic [31:0]  regs [NREG];

  wire addr_ph = idle_q & ~frame_n;
  wire is_io   = cbe_n[3:1] == 3'b001;
  wire is_mem  = cbe_n[3:1] == 3'b011;
  wire is_cfg  = cbe_n[3:1] == 3'b101;
  wire cfg_hit = is_cfg & idsel & (ad_in[1:0] == 2'b00);
  wire mem_hit = is_mem & mem_base[0] & (ad_in[31:WB] == mem_base[31:WB]);
  wire io_hit  = is_io  & io_base[0]  & (ad_in[31:WB] == io_base[31:WB]);
  wire hit     = addr_ph & ~bus_master & (cfg_hit | mem_hit | io_hit);
  wire wr_go   = (st == S_XFER) & ~irdy_n & ~rd_q;

  assign devsel_n = (st != S_XFER);
  assign trdy_n   = (st != S_XFER);
  assign ctl_oe   = (st == S_XFER) | (st == S_TAR);
  assign ad_oe    = (st == S_XFER) & rd_q;

  always_comb begin
    ad_out = 32'h0;
    if (cfg_q) begin
      if (cidx_q == 6'd0)      ad_out = mem_base;
      else if (cidx_q == 6'd1) ad_out = io_base;
    end else begin
      ad_out = regs[ridx_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idle_q <= 1'b1;
      rd_q   <= 1'b0;
      cfg_q  <= 1'b0;
      cidx_q <= '0;
      ridx_q <= '0;
    end else begin
      idle_q <= frame_n & irdy_n;
      case (st)
        S_IDLE: if (hit) begin
          st     <= S_DEC;
          rd_q   <= ~cbe_n[0];
          cfg_q  <= is_cfg;
          cidx_q <= ad_in[7:2];
          ridx_q <= ad_in[WB-1:2];
        end
        S_DEC:  st <= S_XFER;
        S_XFER: if (!irdy_n) st <= S_TAR;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_base <= '0;
      io_base  <= '0;
    end else if (wr_go && cfg_q) begin
      for (int b = 0; b < 4; b++) begin
        if (!cbe_n[b]) begin
          if (cidx_q == 6'd0) mem_base[8*b +: 8] <= ad_in[8*b +: 8] & BMASK[8*b +: 8];
          if (cidx_q == 6'd1) io_base[8*b +: 8]  <= ad_in[8*b +: 8] & BMASK[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_go && !cfg_q) begin
      for (int b = 0; b < 4; b++)
        if (!cbe_n[b]) regs[ridx_q][8*b +: 8] <= ad_in[8*b +: 8];
    end
  end

  assert_medium_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && $past(devsel_n)) |-> $past(!frame_n, 2));

  assert_strobes_paired_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> (devsel_n == trdy_n));

  assert_ad_only_when_claimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!devsel_n && ctl_oe));

  assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!devsel_n) && devsel_n) |-> (ctl_oe && !ad_oe));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && devsel_n) |=> !ctl_oe);

  assert_master_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && bus_master) |=> ##1 devsel_n);
endmodule

// File: tb/pci_target_claim_test.sv
`timescale 1ns/1ps
module pci_target_claim_test;
  localparam int CLK_NS = 20;
  localparam logic [31:0] BMASK = 32'hFFFF_FFF1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_master = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, ctl_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_mem = '0, m_io = '0;
  logic [31:0] m_reg [4] = '{default: '0};

  pci_target_claim #(.NREG(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_master(bus_master), .frame_n(frame_n),
    .irdy_n(irdy_n), .idsel(idsel), .cbe_n(cbe_n), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .ctl_oe(ctl_oe));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_claim(input logic [3:0] cmd, input logic [31:0] a, input bit ids, input bit mst);
    if (mst) return 0;
    case (cmd[3:1])
      3'b001:  return m_io[0]  && a[31:4] == m_io[31:4];
      3'b011:  return m_mem[0] && a[31:4] == m_mem[31:4];
      3'b101:  return ids && a[1:0] == 2'b00;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] cmd, input logic [31:0] a);
    if (cmd[3:1] == 3'b101) return (a[7:2] == 0) ? m_mem : (a[7:2] == 1) ? m_io : 32'h0;
    return m_reg[a[3:2]];
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
    for (int b = 0; b < 4; b++) if (!be[b]) old[8*b +: 8] = d[8*b +: 8];
    return old;
  endfunction

  task automatic model_write(input logic [3:0] cmd, input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    if (cmd[3:1] == 3'b101) begin
      if (a[7:2] == 0) m_mem = merge(m_mem, d, be) & BMASK;
      else if (a[7:2] == 1) m_io = merge(m_io, d, be) & BMASK;
    end else m_reg[a[3:2]] = merge(m_reg[a[3:2]], d, be);
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] a, input bit ids, input bit mst,
                     input logic [3:0] be, input logic [31:0] wd, input int waits, input string tag);
    bit claim, rd;
    logic [31:0] er;
    claim = exp_claim(cmd, a, ids, mst);
    rd = !cmd[0];
    er = exp_read(cmd, a);
    @(negedge clk);
    frame_n = 0; ad_in = a; cbe_n = cmd; idsel = ids; bus_master = mst;
    @(negedge clk);
    frame_n = 1; idsel = 0; bus_master = 0; cbe_n = be;
    ad_in = rd ? $urandom : wd;
    irdy_n = (waits > 0);
    chk(devsel_n && !ctl_oe, "R7 no claim one clock after address", {devsel_n, ctl_oe}, 2'b10);
    @(negedge clk);
    if (claim) begin
      chk(!devsel_n && !trdy_n && ctl_oe, {tag, " R7 claimed"}, {devsel_n, trdy_n, ctl_oe}, 3'b001);
      chk(ad_oe == rd, "R8 AD drive on read only", ad_oe, rd);
      if (rd) chk(ad_out == er, {tag, " R8 read data"}, ad_out, er);
    end else
      chk(devsel_n && !ctl_oe && !ad_oe, {tag, " R11 unclaimed stays quiet"}, {devsel_n, ctl_oe, ad_oe}, 3'b100);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      if (claim) chk(!devsel_n && ctl_oe, "R8 claim held through wait", {devsel_n, ctl_oe}, 2'b01);
      else chk(devsel_n && !ctl_oe, "R11 unclaimed during wait", {devsel_n, ctl_oe}, 2'b10);
      if (w == waits - 1) irdy_n = 0;
    end
    @(negedge clk);
    if (claim) begin
      chk(devsel_n && trdy_n && ctl_oe && !ad_oe, "R10 turnaround clock", {devsel_n, trdy_n, ctl_oe, ad_oe}, 4'b1110);
      if (!rd) model_write(cmd, a, be, wd);
    end else
      chk(devsel_n && !ctl_oe, "R11 unclaimed after data", {devsel_n, ctl_oe}, 2'b10);
    irdy_n = 1; ad_in = $urandom; cbe_n = 4'hF;
    @(negedge clk);
    chk(!ctl_oe && devsel_n && !ad_oe, "R10 released", {ctl_oe, devsel_n, ad_oe}, 3'b010);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] cmds [8] = '{4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1010, 4'b1011, 4'b0000, 4'b1110};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(devsel_n && trdy_n && !ctl_oe && !ad_oe, "R1 reset outputs", {devsel_n, trdy_n, ctl_oe, ad_oe}, 4'b1100);
    txn(4'b0110, 32'h0, 0, 0, 4'h0, 0, 0, "R1 memory disabled after reset");
    txn(4'b1011, 32'h0000_0000, 1, 0, 4'h0, 32'h8000_00A3, 0, "R3 write memory base");
    txn(4'b1011, 32'h0000_0004, 1, 0, 4'h0, 32'h0000_C0F1, 1, "R3 write io base");
    txn(4'b1010, 32'h0000_0000, 1, 0, 4'h0, 0, 0, "R3 read memory base masked");
    txn(4'b1010, 32'h0000_0004, 1, 0, 4'h0, 0, 0, "R3 read io base");
    txn(4'b1010, 32'h0000_0000, 0, 0, 4'h0, 0, 0, "R3 idsel low");
    txn(4'b1010, 32'h0000_0001, 1, 0, 4'h0, 0, 0, "R3 AD10 nonzero");
    txn(4'b1011, 32'h0000_0014, 1, 0, 4'h0, 32'hDEAD_BEEF, 0, "R3 write unused index");
    txn(4'b1010, 32'h0000_0014, 1, 0, 4'h0, 0, 0, "R3 unused index reads 0");
    txn(4'b0111, 32'h8000_00A8, 0, 0, 4'h0, 32'h1122_3344, 0, "R4 memory write");
    txn(4'b0111, 32'h8000_00A8, 0, 0, 4'b1010, 32'hAABB_CCDD, 2, "R9 partial byte write");
    txn(4'b0110, 32'h8000_00A8, 0, 0, 4'h0, 0, 0, "R9 R4 memory readback");
    txn(4'b0011, 32'h0000_C0F4, 0, 0, 4'b0110, 32'h5566_7788, 0, "R5 io write");
    txn(4'b0010, 32'h0000_C0F4, 0, 0, 4'h0, 0, 2, "R5 io read");
    txn(4'b0110, 32'h8000_00B0, 0, 0, 4'h0, 0, 0, "R4 outside memory window");
    txn(4'b0000, 32'h8000_00A8, 0, 0, 4'h0, 0, 0, "R6 undefined command");
    txn(4'b1110, 32'h8000_00A8, 0, 0, 4'h0, 0, 0, "R6 other command");
    txn(4'b0110, 32'h8000_00A8, 0, 1, 4'h0, 0, 0, "R6 device is master");
    // R2: frame stays low; matching address on the second clock must not be decoded
    @(negedge clk);
    frame_n = 0; ad_in = 32'h0; cbe_n = 4'b0001;
    @(negedge clk);
    ad_in = 32'h8000_00A8; cbe_n = 4'b0110; irdy_n = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(devsel_n && !ctl_oe, "R2 no decode inside a transaction", {devsel_n, ctl_oe}, 2'b10);
    end
    frame_n = 1;
    @(negedge clk);
    irdy_n = 1;
    @(negedge clk);
    chk(devsel_n && !ctl_oe, "R2 still unclaimed", {devsel_n, ctl_oe}, 2'b10);
    for (int n = 0; n < 400; n++) begin
      logic [3:0] cmd;
      logic [31:0] a;
      int mode;
      cmd = cmds[$urandom_range(7)];
      mode = $urandom_range(3);
      case (mode)
        0: a = {m_mem[31:4], 2'($urandom_range(3)), 2'b00};
        1: a = {m_io[31:4], 2'($urandom_range(3)), 2'($urandom_range(3))};
        2: a = {24'h0, 6'($urandom_range(3)), 2'($urandom_range(3) == 0 ? 1 : 0)};
        default: a = $urandom;
      endcase
      if (cmd == 4'b1011 && a[7:2] < 2) a[7:2] = 6'd2 + 6'(a[2]);
      txn(cmd, a, $urandom_range(3) != 0, $urandom_range(9) == 0, 4'($urandom),
          $urandom, $urandom_range(2), "random");
    end
    txn(4'b0110, 32'h8000_00A0, 0, 0, 4'h0, 0, 0, "R4 final readback");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule